// File: doc/BRIEF.md
# UART Interrupt Cause Collector

This block gathers the interrupt sources of a serial port into one 32-bit status word and drives a single active-high interrupt request. Five causes are tracked, each as its own sticky bit: a receive line error, receive data available, receive character timeout, transmit space available and a modem line change. Any number of them can be pending together. Software reads the status word once, sees every pending cause, and that read clears what it returned. An event that lands in the same cycle as the read is kept pending for the next read.

The status word also carries the modem status byte, with the live levels of CTS, DSR, RI and DCD and two delta flags that record a change on CTS or DCD since the last status read. A configuration register holds the per-source enables and an automatic flow control switch. While that switch is on, modem line changes never raise an interrupt. A timeout register scales a character-timeout timer: after the last received character, with the receive FIFO not empty, the timeout cause is raised after timeout × baud divisor × 4 clock cycles.

The serial shifters, FIFOs and baud generator sit outside; their event strobes, the FIFO empty level and the baud divisor arrive as inputs. All register access goes through plain single-cycle read and write strobes. No port carries a data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `uart_irq_status`

## Requirements
- R1: The status word holds the cause bits at fixed positions: bit 0 line error, bit 1 receive data, bit 2 character timeout, bit 3 transmit space, bit 4 modem change. Several can be set together, and one read of address 0 returns all of them.
- R2: A read of the status word (reg_rd high with reg_addr 0) clears, at the next clock edge, every cause bit and both modem delta bits that it returned.
- R3: A cause whose enabled event strobe is high in the same cycle as a status read is set after that edge and is not lost.
- R4: A cause bit is set only when its enable in the configuration register (address 1) is 1: bit 0 gates receive data and character timeout, bit 1 transmit space, bit 2 line error, bit 3 modem change.
- R5: While configuration bit 4 (automatic flow control) is 1, no modem-change cause is set, whatever the modem enable says.
- R6: Bits 15:8 of the status word are the modem byte, uninverted: bit 12 CTS, bit 13 DSR, bit 14 RI, bit 15 DCD, each one cycle behind its input. Bits 31:16 and 7:5 read 0.
- R7: A change on CTS sets delta bit 8 and a change on DCD sets delta bit 11, one edge after the input changes. A change on DSR or RI sets no delta. Either delta event is the modem-change source.
- R8: The character-timeout cause is set timeout × baud_div × 4 clock edges after the edge that samples rx_char, when the receive FIFO stays non-empty. A timeout value of 0 disables the timer.
- R9: A new rx_char restarts the timer from zero. The timer stops without firing when rx_empty is high, and fires at most once per received character.
- R10: irq is high exactly when at least one cause bit is pending, and falls only after a status read.
- R11: Address 1 reads the 5-bit configuration and address 2 reads the timeout value, each zero-extended. After reset, all registers, causes and irq are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, also the timeout reference |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Write strobe, one cycle |
| reg_rd | input | 1 | Read strobe, one cycle; a status read is destructive |
| reg_addr | input | 2 | Register select: 0 status, 1 configuration, 2 timeout |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from reg_addr |
| baud_div | input | BAUD_W | Current baud divisor |
| rx_char | input | 1 | Strobe: a character entered the receive FIFO |
| rx_empty | input | 1 | Level: receive FIFO empty |
| rda_evt | input | 1 | Strobe: receive data available |
| line_err_evt | input | 1 | Strobe: receive line error |
| tx_space_evt | input | 1 | Strobe: transmit space available |
| cts | input | 1 | Clear-to-send level, active high |
| dsr | input | 1 | Data-set-ready level, active high |
| ri | input | 1 | Ring indicator level, active high |
| dcd | input | 1 | Carrier detect level, active high |
| irq | output | 1 | Interrupt request, active high |

## Verification
The assertions take the modem inputs as already synchronous to clk and the event strobes as single-cycle pulses. They also take the modem inputs as low when reset is released, so that no delta appears from the reset values. The bench drives every input on the falling edge and holds the modem lines low through reset. It keeps reg_addr at 0 while idle, so reg_rdata shows the status word without clearing it, and asserts reg_rd only for deliberate reads.

// File: rtl/uart_irq_pkg.sv
`timescale 1ns/1ps
package uart_irq_pkg;
  // cause bit positions, decoded by software
  localparam int CAUSE_N   = 5;
  localparam int CI_LINE   = 0;
  localparam int CI_RDATA  = 1;
  localparam int CI_TMO    = 2;
  localparam int CI_TXSP   = 3;
  localparam int CI_MODEM  = 4;

  // configuration bits
  localparam int CFG_W       = 5;
  localparam int CB_RX_EN    = 0;
  localparam int CB_TX_EN    = 1;
  localparam int CB_LS_EN    = 2;
  localparam int CB_MS_EN    = 3;
  localparam int CB_AUTOFLOW = 4;

  // modem byte layout
  localparam int MB_DCTS = 0;
  localparam int MB_DDCD = 3;
  localparam int MB_CTS  = 4;
  localparam int MB_DSR  = 5;
  localparam int MB_RI   = 6;
  localparam int MB_DCD  = 7;

  localparam int WORD_W = 32;
  localparam int MSR_LSB = 8;

  typedef enum logic [1:0] {
    RA_STATUS  = 2'd0,
    RA_CONFIG  = 2'd1,
    RA_TIMEOUT = 2'd2,
    RA_RSVD    = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/uart_irq_timeout.sv
`timescale 1ns/1ps
module uart_irq_timeout #(
  parameter int TMO_W  = 8,
  parameter int BAUD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TMO_W-1:0]  tmo_val,
  input  logic [BAUD_W-1:0] baud_div,
  input  logic              rx_char,
  input  logic              rx_empty,
  output logic              expire
);
  localparam int MUL_W  = TMO_W + BAUD_W;
  localparam int PROD_W = MUL_W + 2;

  logic [MUL_W-1:0]  mul;
  logic [PROD_W-1:0] limit;
  logic [PROD_W-1:0] cnt_q;
  logic              armed_q;
  logic              limit_zero;
  logic              at_end;

  always_comb begin
    mul        = MUL_W'(tmo_val) * MUL_W'(baud_div);
    limit      = {mul, 2'b00};
    limit_zero = (limit == '0);
    at_end     = (cnt_q == limit - PROD_W'(1));
    expire     = armed_q && !rx_empty && !rx_char && !limit_zero && at_end;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (rx_char) begin
      armed_q <= 1'b1;
      cnt_q   <= '0;
    end else if (armed_q) begin
      if (rx_empty || limit_zero || expire) begin
        armed_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + PROD_W'(1);
      end
    end
  end
endmodule

// File: rtl/uart_irq_modem.sv
`timescale 1ns/1ps
module uart_irq_modem
  import uart_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cts,
  input  logic       dsr,
  input  logic       ri,
  input  logic       dcd,
  input  logic       clr_delta,
  output logic [7:0] msr,
  output logic       change
);
  logic cts_q, dsr_q, ri_q, dcd_q;
  logic dcts_q, ddcd_q;
  logic cts_chg, dcd_chg;

  always_comb begin
    cts_chg = cts ^ cts_q;
    dcd_chg = dcd ^ dcd_q;
    change  = cts_chg | dcd_chg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cts_q  <= 1'b0;
      dsr_q  <= 1'b0;
      ri_q   <= 1'b0;
      dcd_q  <= 1'b0;
      dcts_q <= 1'b0;
      ddcd_q <= 1'b0;
    end else begin
      cts_q  <= cts;
      dsr_q  <= dsr;
      ri_q   <= ri;
      dcd_q  <= dcd;
      dcts_q <= cts_chg | (dcts_q & ~clr_delta);
      ddcd_q <= dcd_chg | (ddcd_q & ~clr_delta);
    end
  end

  always_comb begin
    msr          = '0;
    msr[MB_DCTS] = dcts_q;
    msr[MB_DDCD] = ddcd_q;
    msr[MB_CTS]  = cts_q;
    msr[MB_DSR]  = dsr_q;
    msr[MB_RI]   = ri_q;
    msr[MB_DCD]  = dcd_q;
  end
endmodule

// File: rtl/uart_irq_cause_bank.sv
`timescale 1ns/1ps
module uart_irq_cause_bank #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic [N-1:0] en,
  input  logic         clr,
  output logic [N-1:0] pend
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bit_q <= 1'b0;
      end else if (evt[i] && en[i]) begin
        bit_q <= 1'b1;          // a new event wins over a clearing read
      end else if (clr) begin
        bit_q <= 1'b0;
      end
    end
    assign pend[i] = bit_q;
  end
endmodule

// File: rtl/uart_irq_status.sv
`timescale 1ns/1ps
module uart_irq_status
  import uart_irq_pkg::*;
#(
  parameter int TMO_W  = 8,
  parameter int BAUD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [BAUD_W-1:0] baud_div,
  input  logic              rx_char,
  input  logic              rx_empty,
  input  logic              rda_evt,
  input  logic              line_err_evt,
  input  logic              tx_space_evt,
  input  logic              cts,
  input  logic              dsr,
  input  logic              ri,
  input  logic              dcd,
  output logic              irq
);
  logic [CFG_W-1:0]   cfg_q;
  logic [TMO_W-1:0]   tmo_q;
  logic [CAUSE_N-1:0] cause_evt;
  logic [CAUSE_N-1:0] cause_en;
  logic [CAUSE_N-1:0] pend;
  logic [7:0]         msr;
  logic               modem_chg;
  logic               tmo_fire;
  logic               rd_status;
  reg_addr_e          addr;

  always_comb begin
    addr      = reg_addr_e'(reg_addr);
    rd_status = reg_rd && (addr == RA_STATUS);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      tmo_q <= '0;
    end else if (reg_wr) begin
      if (addr == RA_CONFIG)  cfg_q <= reg_wdata[CFG_W-1:0];
      if (addr == RA_TIMEOUT) tmo_q <= reg_wdata[TMO_W-1:0];
    end
  end

  uart_irq_timeout #(.TMO_W(TMO_W), .BAUD_W(BAUD_W)) u_tmo (
    .clk      (clk),
    .rst_n    (rst_n),
    .tmo_val  (tmo_q),
    .baud_div (baud_div),
    .rx_char  (rx_char),
    .rx_empty (rx_empty),
    .expire   (tmo_fire)
  );

  uart_irq_modem u_modem (
    .clk       (clk),
    .rst_n     (rst_n),
    .cts       (cts),
    .dsr       (dsr),
    .ri        (ri),
    .dcd       (dcd),
    .clr_delta (rd_status),
    .msr       (msr),
    .change    (modem_chg)
  );

  always_comb begin
    cause_evt           = '0;
    cause_evt[CI_LINE]  = line_err_evt;
    cause_evt[CI_RDATA] = rda_evt;
    cause_evt[CI_TMO]   = tmo_fire;
    cause_evt[CI_TXSP]  = tx_space_evt;
    cause_evt[CI_MODEM] = modem_chg;

    cause_en            = '0;
    cause_en[CI_LINE]   = cfg_q[CB_LS_EN];
    cause_en[CI_RDATA]  = cfg_q[CB_RX_EN];
    cause_en[CI_TMO]    = cfg_q[CB_RX_EN];
    cause_en[CI_TXSP]   = cfg_q[CB_TX_EN];
    cause_en[CI_MODEM]  = cfg_q[CB_MS_EN] & ~cfg_q[CB_AUTOFLOW];
  end

  uart_irq_cause_bank #(.N(CAUSE_N)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .evt   (cause_evt),
    .en    (cause_en),
    .clr   (rd_status),
    .pend  (pend)
  );

  always_comb begin
    reg_rdata = '0;
    unique case (addr)
      RA_STATUS: begin
        reg_rdata[CAUSE_N-1:0]          = pend;
        reg_rdata[MSR_LSB+7:MSR_LSB]    = msr;
      end
      RA_CONFIG:  reg_rdata[CFG_W-1:0] = cfg_q;
      RA_TIMEOUT: reg_rdata[TMO_W-1:0] = tmo_q;
      default:    reg_rdata = '0;
    endcase
    irq = |pend;
  end
endmodule

// File: rtl/uart_irq_status_chk.sv
`timescale 1ns/1ps
module uart_irq_status_chk
  import uart_irq_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               rd_status,
  input logic [CAUSE_N-1:0] cause_evt,
  input logic [CAUSE_N-1:0] cause_en,
  input logic [CAUSE_N-1:0] pend,
  input logic [CFG_W-1:0]   cfg_q,
  input logic               rx_empty,
  input logic               irq
);
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_status && ((cause_evt & cause_en) == '0)) |=> (pend == '0)); // R2

  AST_EVENT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_status && cause_evt[CI_RDATA] && cfg_q[CB_RX_EN]) |=> pend[CI_RDATA]); // R3

  AST_RX_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_q[CB_RX_EN] && !pend[CI_RDATA]) |=> !pend[CI_RDATA]); // R4

  AST_NO_MODEM_AUTOFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q[CB_AUTOFLOW] && !pend[CI_MODEM]) |=> !pend[CI_MODEM]); // R5

  AST_TMO_HELD_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_empty && !pend[CI_TMO]) |=> !pend[CI_TMO]); // R9

  AST_IRQ_FALL_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(rd_status)); // R10
endmodule

bind uart_irq_status uart_irq_status_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rd_status (rd_status),
  .cause_evt (cause_evt),
  .cause_en  (cause_en),
  .pend      (pend),
  .cfg_q     (cfg_q),
  .rx_empty  (rx_empty),
  .irq       (irq)
);

// File: tb/uart_irq_status_tb.sv
`timescale 1ns/1ps
module uart_irq_status_tb;
  localparam int BAUD_W = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0]        reg_addr = 2'd0;
  logic [31:0]       reg_wdata = '0;
  logic [31:0]       reg_rdata;
  logic [BAUD_W-1:0] baud_div = 8'd1;
  logic              rx_char = 1'b0, rx_empty = 1'b1;
  logic              rda_evt = 1'b0, line_err_evt = 1'b0, tx_space_evt = 1'b0;
  logic              cts = 1'b0, dsr = 1'b0, ri = 1'b0, dcd = 1'b0;
  logic              irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  uart_irq_status u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .baud_div(baud_div), .rx_char(rx_char), .rx_empty(rx_empty),
    .rda_evt(rda_evt), .line_err_evt(line_err_evt), .tx_space_evt(tx_space_evt),
    .cts(cts), .dsr(dsr), .ri(ri), .dcd(dcd), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 2'd0;
  endtask

  task automatic read_reg(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0; reg_addr = 2'd0;
  endtask

  task automatic pulse_rx_char();
    @(negedge clk); rx_char = 1'b1;
    @(negedge clk); rx_char = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // number of negedges until the timeout cause shows, counted after rx_char
  task automatic measure_tmo(output int n);
    n = 0;
    while (reg_rdata[2] == 1'b0 && n < 400) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'd0, 32'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] exp;
    logic        cts_v;
    int          n;

    idle(5);
    rst_n = 1'b1;
    idle(2);

    // R11 reset state
    #1 check(irq == 1'b0, "R11 irq after reset", {31'd0, irq}, 32'd0);
    read_reg(2'd0, v); check(v == 32'd0, "R11 status reset", v, 32'd0);
    read_reg(2'd1, v); check(v == 32'd0, "R11 config reset", v, 32'd0);
    read_reg(2'd2, v); check(v == 32'd0, "R11 timeout reset", v, 32'd0);

    // R11 readback of config and timeout
    write_reg(2'd1, 32'hFFFF_FFF5);
    read_reg(2'd1, v); check(v == 32'h15, "R11 config readback", v, 32'h15);
    write_reg(2'd2, 32'h0000_01A7);
    read_reg(2'd2, v); check(v == 32'hA7, "R11 timeout readback", v, 32'hA7);
    write_reg(2'd2, 32'd0);

    // R1 R4 R5 R6 R7 R10 R2: sweep all enable masks
    cts_v = 1'b0;
    for (int m = 0; m < 32; m++) begin
      logic [4:0] mk;
      mk = 5'(m);
      write_reg(2'd1, {27'd0, mk});
      read_reg(2'd0, v);
      @(negedge clk);
      line_err_evt = 1'b1; rda_evt = 1'b1; tx_space_evt = 1'b1;
      cts_v = ~cts_v; cts = cts_v;
      @(negedge clk);
      line_err_evt = 1'b0; rda_evt = 1'b0; tx_space_evt = 1'b0;
      exp = 32'd0;
      exp[0] = mk[2];
      exp[1] = mk[0];
      exp[3] = mk[1];
      exp[4] = mk[3] & ~mk[4];
      exp[8] = 1'b1;
      exp[12] = cts_v;
      #1 check(irq == (exp[4:0] != 5'd0), "R10 irq level", {31'd0, irq},
               {31'd0, (exp[4:0] != 5'd0)});
      read_reg(2'd0, v);
      check(v == exp, "R1 R4 R5 R7 causes by mask", v, exp);
      read_reg(2'd0, v);
      exp = {19'd0, cts_v, 12'd0};
      check(v == exp, "R2 cleared after read", v, exp);
      #1 check(irq == 1'b0, "R10 irq low after read", {31'd0, irq}, 32'd0);
    end

    // R6 R7 modem byte layout and DCD delta
    write_reg(2'd1, 32'h8);
    read_reg(2'd0, v);
    @(negedge clk); dcd = 1'b1; dsr = 1'b1; ri = 1'b1;
    @(negedge clk);
    read_reg(2'd0, v);
    exp = 32'd0; exp[15] = 1'b1; exp[14] = 1'b1; exp[13] = 1'b1;
    exp[12] = cts_v; exp[11] = 1'b1; exp[4] = 1'b1;
    check(v == exp, "R6 R7 dcd dsr ri levels", v, exp);
    @(negedge clk); dsr = 1'b0; ri = 1'b0;
    @(negedge clk);
    read_reg(2'd0, v);
    exp = 32'd0; exp[15] = 1'b1; exp[12] = cts_v;
    check(v == exp, "R7 dsr ri change no delta", v, exp);
    @(negedge clk); dcd = 1'b0;
    @(negedge clk);
    read_reg(2'd0, v);

    // R3 event in the same cycle as a status read
    write_reg(2'd1, 32'h1);
    read_reg(2'd0, v);
    @(negedge clk); reg_rd = 1'b1; reg_addr = 2'd0; rda_evt = 1'b1;
    @(negedge clk); reg_rd = 1'b0; rda_evt = 1'b0;
    #1 check(reg_rdata[1] == 1'b1, "R3 event kept during read",
             {31'd0, reg_rdata[1]}, 32'd1);
    read_reg(2'd0, v);

    // R8 timeout length sweep
    rx_empty = 1'b0;
    for (int t = 1; t <= 3; t++) begin
      for (int b = 1; b <= 3; b++) begin
        baud_div = 8'(b);
        write_reg(2'd2, 32'(t));
        read_reg(2'd0, v);
        pulse_rx_char();
        measure_tmo(n);
        check(n == 4 * t * b, "R8 timeout length", 32'(n), 32'(4 * t * b));
        read_reg(2'd0, v);
        idle(8 * t * b + 4);
        #1 check(reg_rdata[2] == 1'b0, "R9 fires once", {31'd0, reg_rdata[2]}, 32'd0);
      end
    end

    // R9 restart on a new character
    baud_div = 8'd2;
    write_reg(2'd2, 32'd2);
    read_reg(2'd0, v);
    pulse_rx_char();
    idle(10);
    pulse_rx_char();
    measure_tmo(n);
    check(n == 16, "R9 restart on rx_char", 32'(n), 32'd16);
    read_reg(2'd0, v);

    // R9 stop when FIFO empty
    pulse_rx_char();
    rx_empty = 1'b1;
    idle(40);
    #1 check(reg_rdata[2] == 1'b0, "R9 stopped on empty", {31'd0, reg_rdata[2]}, 32'd0);
    rx_empty = 1'b0;

    // R8 zero timeout disables the timer
    write_reg(2'd2, 32'd0);
    pulse_rx_char();
    idle(40);
    #1 check(reg_rdata[2] == 1'b0, "R8 zero timeout", {31'd0, reg_rdata[2]}, 32'd0);

    // R4 timeout gated by receive enable
    write_reg(2'd1, 32'h0);
    write_reg(2'd2, 32'd1);
    baud_div = 8'd1;
    pulse_rx_char();
    idle(10);
    #1 check(reg_rdata[2] == 1'b0, "R4 timeout gated", {31'd0, reg_rdata[2]}, 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule